// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. Each request carries a privilege index (kernel or user) and a set of requested access kinds. The block first screens the address. An address whose upper bits are not a proper sign extension is refused. A negative address in the direct-mapped kernel window is translated at once, with no memory traffic. Every other address is resolved by reading up to three 8-byte table entries through a single-outstanding memory read port.

The leaf entry is then checked in two steps. Its per-privilege enable bits decide what may be granted. Its fault-on bits then withdraw permissions that had been granted. The block reports the physical address, the permissions that remain, and a fault code. A one-cycle done pulse marks the end of each accepted request.

Encodings used throughout:
- Access and permission vectors: bit 0 is read, bit 1 is write, bit 2 is execute.
- Privilege: 0 is kernel, 1 is user.
- Fault codes: 0 none, 1 not-valid, 2 access violation, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute.
- Pages are 8 KB (13 offset bits) and the implemented virtual space is 43 bits.

Top module: `pgwalk_top`

## Requirements
- R1: An address whose bits 63:43 are neither all zero nor all one completes with fault 2 (access violation). done_o is high in the cycle after acceptance, and no memory read is issued.
- R2: A kernel request (privilege 0) for an address with bit 63 set and bits 42:41 equal to 2'b10, and with correct sign extension, completes in the cycle after acceptance with no memory read. It gives fault 0, perm_o = 3'b111, and pa_o equal to virtual bits 39:0, with virtual bit 40 copied to physical bit 43 and all other bits zero.
- R3: The same window requested at user privilege (privilege 1) completes in the cycle after acceptance with fault 2 and no memory read.
- R4: The three reads go to ptbr_i + va[42:33]*8, then to (E1[63:32] << 13) + va[32:23]*8, then to (E2[63:32] << 13) + va[22:13]*8. Here E1 and E2 are the first- and second-level entries.
- R5: A first- or second-level entry with bit 0 (valid) clear ends the walk with fault 1. A valid entry with bit 8 (kernel read enable) clear ends it with fault 2. No further read is issued in either case.
- R6: A leaf entry with bit 0 clear gives fault 1.
- R7: In the leaf entry, bit 8+priv grants read and execute, and bit 12+priv grants write. A nonzero request that shares no bit with the granted set gives fault 2.
- R8: Leaf bits 1, 2 and 3 withdraw read, write and execute respectively. If a nonzero request then shares no bit with what remains, the fault is 5 when execute was requested, else 4 when write was requested, else 3.
- R9: A successful walk gives fault 0, pa_o = (leaf[63:32] << 13) | va[12:0], and perm_o equal to the permissions left after R8. A request of 3'b000 succeeds whenever the leaf is valid.
- R10: mem_req_o stays high with a stable mem_addr_o until mem_gnt_i is seen. It is not raised again until mem_rvalid_i has returned the previous read, so at most one read is outstanding.
- R11: ready_o is high only when idle, and done_o is a one-cycle pulse. Whenever the fault is nonzero, pa_o and perm_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when ready_o is high |
| ready_o | output | 1 | Walker idle and able to accept a request |
| va_i | input | 64 | Virtual address |
| priv_i | input | 1 | Privilege index: 0 kernel, 1 user |
| acc_i | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| ptbr_i | input | 64 | Physical base of the first-level table |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 64 | Table entry physical address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry read data |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 64 | Physical address (zero on fault) |
| perm_o | output | 3 | Granted permissions (zero on fault) |
| fault_o | output | 3 | Fault code |

## Verification
Directed vectors cover several outcomes. A malformed sign extension, and the direct window at both privileges, show that the early exits take no memory traffic. A missing valid bit or kernel-read bit at each table level shows which level stops the walk. Leaf vectors with chosen enable and fault-on bits separate the access-violation code from the three fault-on codes, and show the execute-over-write-over-read order when several bits are requested. Random vectors then mix all four address classes with randomly populated entries and random memory grant and response delays. Each result is compared against a bench model of the translation rules, which also checks every table address presented on the read port.

// File: rtl/pgwalk_pkg.sv
// Package: shared constants and types of the page table walker.
// Assumes 8-byte table entries and three table levels.
package pgwalk_pkg;

    localparam int unsigned PW_VA_BITS    = 43;  // implemented virtual bits
    localparam int unsigned PW_PAGE_BITS  = 13;  // 8 KB page
    localparam int unsigned PW_LVL_BITS   = 10;  // index width per level
    localparam int unsigned PW_ENT_SHIFT  = 3;   // 8-byte entries
    localparam int unsigned PW_VALID_BIT  = 0;
    localparam int unsigned PW_FO_BIT     = 1;   // FOR, FOW, FOE at 1..3
    localparam int unsigned PW_RD_EN_BIT  = 8;   // kernel read enable, user +1
    localparam int unsigned PW_WR_EN_BIT  = 12;  // kernel write enable, user +1
    localparam int unsigned PW_WIN_LO     = 41;  // direct window selector bits
    localparam int unsigned PW_WIN_KEEP   = 40;  // low bits passed straight
    localparam int unsigned PW_WIN_DEST   = 43;  // destination of bit 40

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_TNV  = 3'd1,
        FLT_ACV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } pw_fault_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_L1    = 3'd1,
        ST_L2    = 3'd2,
        ST_L3    = 3'd3,
        ST_CHECK = 3'd4,
        ST_DONE  = 3'd5
    } pw_state_e;

endpackage

// File: rtl/pgwalk_precheck.sv
// Module: address screening before any table access.
// Flags a malformed sign extension and recognises the direct-mapped
// kernel window, producing its relocated physical address.
// Assumes VA_BITS < 64 and WIN_LO + 1 < VA_BITS.
module pgwalk_precheck #(
    parameter int unsigned VA_BITS  = pgwalk_pkg::PW_VA_BITS,
    parameter int unsigned WIN_LO   = pgwalk_pkg::PW_WIN_LO,
    parameter int unsigned WIN_KEEP = pgwalk_pkg::PW_WIN_KEEP,
    parameter int unsigned WIN_DEST = pgwalk_pkg::PW_WIN_DEST
) (
    input  logic [63:0] va_i,
    output logic        sign_bad_o,
    output logic        window_o,
    output logic [63:0] window_pa_o
);
    localparam int unsigned HI_W = 64 - VA_BITS;

    logic [HI_W-1:0] hi_bits;
    logic [63:0]     low_keep;
    logic            unused_mid;

    // Upper bits must replicate one value.
    always_comb begin
        hi_bits    = va_i[63:VA_BITS];
        sign_bad_o = (|hi_bits) && !(&hi_bits);
    end

    // Window decode: negative address with selector 2'b10.
    always_comb begin
        window_o = !sign_bad_o && va_i[63] && (va_i[WIN_LO+1:WIN_LO] == 2'b10);
    end

    // Relocated physical address for the direct window.
    always_comb begin
        low_keep    = 64'(va_i[WIN_KEEP-1:0]);
        window_pa_o = low_keep | (64'(va_i[WIN_KEEP]) << WIN_DEST);
    end

    assign unused_mid = ^va_i[VA_BITS-1:WIN_LO+2];

endmodule

// File: rtl/pgwalk_leaf.sv
// Module: leaf entry protection evaluation.
// Derives granted permissions from the per-privilege enable bits,
// withdraws those blocked by fault-on bits and encodes the outcome.
// Assumes priv is 0 (kernel) or 1 (user); user enables sit one bit up.
module pgwalk_leaf #(
    parameter int unsigned PAGE_BITS = pgwalk_pkg::PW_PAGE_BITS,
    parameter int unsigned VALID_BIT = pgwalk_pkg::PW_VALID_BIT,
    parameter int unsigned FO_BIT    = pgwalk_pkg::PW_FO_BIT,
    parameter int unsigned RD_EN_BIT = pgwalk_pkg::PW_RD_EN_BIT,
    parameter int unsigned WR_EN_BIT = pgwalk_pkg::PW_WR_EN_BIT
) (
    input  logic [63:0]           pte_i,
    input  logic                  priv_i,
    input  logic [2:0]            acc_i,
    input  logic [PAGE_BITS-1:0]  offs_i,
    output pgwalk_pkg::pw_fault_e fault_o,
    output logic [2:0]            perm_o,
    output logic [63:0]           pa_o
);
    import pgwalk_pkg::*;

    logic       rd_en;
    logic       wr_en;
    logic [2:0] granted;
    logic [2:0] blocked;
    logic [2:0] remain;
    logic       unused_pte;

    // Enable bits for the current privilege.
    always_comb begin
        rd_en   = priv_i ? pte_i[RD_EN_BIT+1] : pte_i[RD_EN_BIT];
        wr_en   = priv_i ? pte_i[WR_EN_BIT+1] : pte_i[WR_EN_BIT];
        granted = {rd_en, wr_en, rd_en};
        blocked = pte_i[FO_BIT +: 3];
        remain  = granted & ~blocked;
    end

    // Outcome encoding with execute, then write, then read priority.
    always_comb begin
        fault_o = FLT_NONE;
        perm_o  = remain;
        if (!pte_i[VALID_BIT]) begin
            fault_o = FLT_TNV;
        end else if ((acc_i != 3'b000) && ((granted & acc_i) == 3'b000)) begin
            fault_o = FLT_ACV;
        end else if ((acc_i != 3'b000) && ((remain & acc_i) == 3'b000)) begin
            if (acc_i[2])      fault_o = FLT_FOE;
            else if (acc_i[1]) fault_o = FLT_FOW;
            else               fault_o = FLT_FOR;
        end
        if (fault_o != FLT_NONE) perm_o = 3'b000;
    end

    // Physical address from the frame field and the page offset.
    always_comb begin
        pa_o = (64'(pte_i[63:32]) << PAGE_BITS) | 64'(offs_i);
    end

    assign unused_pte = ^{pte_i[31:16], pte_i[11:10], pte_i[7:4]};

endmodule

// File: rtl/pgwalk_ctrl.sv
// Module: walk sequencer.
// Accepts a request, resolves early exits, issues one table read per
// level over a request/grant then response port, and registers the result.
// Assumes the response arrives no earlier than the cycle after the grant.
module pgwalk_ctrl #(
    parameter int unsigned VA_BITS   = pgwalk_pkg::PW_VA_BITS,
    parameter int unsigned PAGE_BITS = pgwalk_pkg::PW_PAGE_BITS,
    parameter int unsigned LVL_BITS  = pgwalk_pkg::PW_LVL_BITS,
    parameter int unsigned ENT_SHIFT = pgwalk_pkg::PW_ENT_SHIFT,
    parameter int unsigned VALID_BIT = pgwalk_pkg::PW_VALID_BIT,
    parameter int unsigned RD_EN_BIT = pgwalk_pkg::PW_RD_EN_BIT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [VA_BITS-1:0]    va_i,
    input  logic                  priv_i,
    input  logic [2:0]            acc_i,
    input  logic [63:0]           ptbr_i,
    input  logic                  sign_bad_i,
    input  logic                  window_i,
    input  logic [63:0]           window_pa_i,
    input  pgwalk_pkg::pw_fault_e leaf_fault_i,
    input  logic [2:0]            leaf_perm_i,
    input  logic [63:0]           leaf_pa_i,
    output logic [PAGE_BITS-1:0]  offs_o,
    output logic                  priv_o,
    output logic [2:0]            acc_o,
    output logic [63:0]           pte_o,
    output logic                  mem_req_o,
    output logic [63:0]           mem_addr_o,
    input  logic                  mem_gnt_i,
    input  logic                  mem_rvalid_i,
    input  logic [63:0]           mem_rdata_i,
    output logic                  ready_o,
    output logic                  done_o,
    output logic [63:0]           pa_o,
    output logic [2:0]            perm_o,
    output logic [2:0]            fault_o
);
    import pgwalk_pkg::*;

    localparam int unsigned SH_L1 = PAGE_BITS + 2 * LVL_BITS;
    localparam int unsigned SH_L2 = PAGE_BITS + LVL_BITS;
    localparam int unsigned SH_L3 = PAGE_BITS;

    pw_state_e            state_q;
    logic [VA_BITS-1:0]   va_q;
    logic                 priv_q;
    logic [2:0]           acc_q;
    logic [63:0]          base_q;
    logic [63:0]          pte_q;
    logic                 issued_q;
    logic [63:0]          pa_q;
    logic [2:0]           perm_q;
    pw_fault_e            fault_q;
    logic [LVL_BITS-1:0]  idx;
    logic                 walking;
    logic [63:0]          next_base;

    // Level index selected by the current state.
    always_comb begin
        case (state_q)
            ST_L1:   idx = va_q[SH_L1 +: LVL_BITS];
            ST_L2:   idx = va_q[SH_L2 +: LVL_BITS];
            default: idx = va_q[SH_L3 +: LVL_BITS];
        endcase
    end

    // Read port drive and next-level base.
    always_comb begin
        walking    = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);
        mem_req_o  = walking && !issued_q;
        mem_addr_o = base_q + (64'(idx) << ENT_SHIFT);
        next_base  = 64'(mem_rdata_i[63:32]) << PAGE_BITS;
    end

    // Sequencer: accept, walk, check, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            priv_q   <= 1'b0;
            acc_q    <= 3'b000;
            base_q   <= '0;
            pte_q    <= '0;
            issued_q <= 1'b0;
            pa_q     <= '0;
            perm_q   <= 3'b000;
            fault_q  <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        va_q   <= va_i;
                        priv_q <= priv_i;
                        acc_q  <= acc_i;
                        base_q <= ptbr_i;
                        pa_q   <= '0;
                        perm_q <= 3'b000;
                        if (sign_bad_i) begin
                            fault_q <= FLT_ACV;
                            state_q <= ST_DONE;
                        end else if (window_i) begin
                            if (priv_i) begin
                                fault_q <= FLT_ACV;
                            end else begin
                                fault_q <= FLT_NONE;
                                pa_q    <= window_pa_i;
                                perm_q  <= 3'b111;
                            end
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_L1;
                        end
                    end
                end
                ST_L1, ST_L2, ST_L3: begin
                    if (!issued_q) begin
                        if (mem_gnt_i) issued_q <= 1'b1;
                    end else if (mem_rvalid_i) begin
                        issued_q <= 1'b0;
                        if (state_q == ST_L3) begin
                            pte_q   <= mem_rdata_i;
                            state_q <= ST_CHECK;
                        end else if (!mem_rdata_i[VALID_BIT]) begin
                            fault_q <= FLT_TNV;
                            state_q <= ST_DONE;
                        end else if (!mem_rdata_i[RD_EN_BIT]) begin
                            fault_q <= FLT_ACV;
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= next_base;
                            state_q <= (state_q == ST_L1) ? ST_L2 : ST_L3;
                        end
                    end
                end
                ST_CHECK: begin
                    fault_q <= leaf_fault_i;
                    perm_q  <= leaf_perm_i;
                    pa_q    <= (leaf_fault_i == FLT_NONE) ? leaf_pa_i : '0;
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Result and status outputs.
    always_comb begin
        ready_o = (state_q == ST_IDLE);
        done_o  = (state_q == ST_DONE);
        pa_o    = pa_q;
        perm_o  = perm_q;
        fault_o = fault_q;
        offs_o  = va_q[PAGE_BITS-1:0];
        priv_o  = priv_q;
        acc_o   = acc_q;
        pte_o   = pte_q;
    end

endmodule

// File: rtl/pgwalk_top.sv
// Module: three-level page table walker, top level.
// Joins address screening, the walk sequencer and leaf evaluation.
// Assumes the table memory answers each granted read exactly once.
module pgwalk_top #(
    parameter int unsigned VA_BITS   = pgwalk_pkg::PW_VA_BITS,
    parameter int unsigned PAGE_BITS = pgwalk_pkg::PW_PAGE_BITS,
    parameter int unsigned LVL_BITS  = pgwalk_pkg::PW_LVL_BITS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        ready_o,
    input  logic [63:0] va_i,
    input  logic        priv_i,
    input  logic [2:0]  acc_i,
    input  logic [63:0] ptbr_i,
    output logic        mem_req_o,
    output logic [63:0] mem_addr_o,
    input  logic        mem_gnt_i,
    input  logic        mem_rvalid_i,
    input  logic [63:0] mem_rdata_i,
    output logic        done_o,
    output logic [63:0] pa_o,
    output logic [2:0]  perm_o,
    output logic [2:0]  fault_o
);
    import pgwalk_pkg::*;

    logic                 sign_bad;
    logic                 window;
    logic [63:0]          window_pa;
    pw_fault_e            leaf_fault;
    logic [2:0]           leaf_perm;
    logic [63:0]          leaf_pa;
    logic [PAGE_BITS-1:0] offs;
    logic                 priv_q;
    logic [2:0]           acc_q;
    logic [63:0]          pte_q;

    pgwalk_precheck #(.VA_BITS(VA_BITS)) i_precheck (
        .va_i        (va_i),
        .sign_bad_o  (sign_bad),
        .window_o    (window),
        .window_pa_o (window_pa)
    );

    pgwalk_ctrl #(
        .VA_BITS   (VA_BITS),
        .PAGE_BITS (PAGE_BITS),
        .LVL_BITS  (LVL_BITS)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .va_i         (va_i[VA_BITS-1:0]),
        .priv_i       (priv_i),
        .acc_i        (acc_i),
        .ptbr_i       (ptbr_i),
        .sign_bad_i   (sign_bad),
        .window_i     (window),
        .window_pa_i  (window_pa),
        .leaf_fault_i (leaf_fault),
        .leaf_perm_i  (leaf_perm),
        .leaf_pa_i    (leaf_pa),
        .offs_o       (offs),
        .priv_o       (priv_q),
        .acc_o        (acc_q),
        .pte_o        (pte_q),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_gnt_i    (mem_gnt_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .ready_o      (ready_o),
        .done_o       (done_o),
        .pa_o         (pa_o),
        .perm_o       (perm_o),
        .fault_o      (fault_o)
    );

    pgwalk_leaf #(.PAGE_BITS(PAGE_BITS)) i_leaf (
        .pte_i   (pte_q),
        .priv_i  (priv_q),
        .acc_i   (acc_q),
        .offs_i  (offs),
        .fault_o (leaf_fault),
        .perm_o  (leaf_perm),
        .pa_o    (leaf_pa)
    );

endmodule

// File: rtl/pgwalk_chk.sv
// Module: protocol and outcome checker bound to pgwalk_top.
// Observes ports only; keeps one counter of reads in flight.
module pgwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        ready_o,
    input logic [63:0] va_i,
    input logic        priv_i,
    input logic        mem_req_o,
    input logic [63:0] mem_addr_o,
    input logic        mem_gnt_i,
    input logic        mem_rvalid_i,
    input logic        done_o,
    input logic [63:0] pa_o,
    input logic [2:0]  perm_o,
    input logic [2:0]  fault_o
);
    logic [1:0] inflight_q;
    logic       addr_bad;
    logic       addr_win;

    // Reads granted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 2'd0;
        end else begin
            case ({mem_req_o && mem_gnt_i, mem_rvalid_i})
                2'b10:   inflight_q <= inflight_q + 2'd1;
                2'b01:   inflight_q <= inflight_q - 2'd1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    // Address classes seen on the request inputs.
    always_comb begin
        addr_bad = (va_i[63:43] != 21'h0) && (va_i[63:43] != 21'h1FFFFF);
        addr_win = !addr_bad && va_i[63] && (va_i[42:41] == 2'b10);
    end

    assert_sign_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && ready_o && addr_bad |=> done_o && (fault_o == 3'd2));

    assert_window_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && ready_o && addr_win && priv_i |=> done_o && (fault_o == 3'd2));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

    assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (inflight_q == 2'd0));

    assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !ready_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fault_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (fault_o != 3'd0) |-> (pa_o == 64'd0) && (perm_o == 3'd0));

endmodule

bind pgwalk_top pgwalk_chk i_pgwalk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ready_o      (ready_o),
    .va_i         (va_i),
    .priv_i       (priv_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .done_o       (done_o),
    .pa_o         (pa_o),
    .perm_o       (perm_o),
    .fault_o      (fault_o)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ready_o;
    logic [63:0] va_i = '0;
    logic        priv_i = 1'b0;
    logic [2:0]  acc_i = '0;
    logic [63:0] ptbr_i = '0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        done_o;
    logic [63:0] pa_o;
    logic [2:0]  perm_o;
    logic [2:0]  fault_o;

    int n_vec = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    logic [63:0] tbl [0:3];
    logic [63:0] seen [0:3];

    always #5 clk = ~clk;

    pgwalk_top i_pgwalk_top (.*);

    // Memory responder: random grant and response delays.
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            mem_gnt_i    = 1'b0;
            if (mem_req_o && ($urandom % 3 != 0)) begin
                mem_gnt_i = 1'b1;
                if (rd_cnt < 4) seen[rd_cnt] = mem_addr_o;
                @(negedge clk);
                mem_gnt_i = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = (rd_cnt < 4) ? tbl[rd_cnt] : 64'd0;
                rd_cnt++;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Bench model of the translation rules.
    task automatic model(input logic [63:0] va, input logic pv, input logic [2:0] acc,
                         input logic [63:0] pt, input logic [63:0] e1,
                         input logic [63:0] e2, input logic [63:0] e3,
                         output logic [2:0] f, output logic [63:0] pa,
                         output logic [2:0] pm, output int nrd,
                         output logic [63:0] a1, output logic [63:0] a2,
                         output logic [63:0] a3, output string tag);
        logic [2:0] g;
        logic [2:0] r;
        f = 3'd0; pa = '0; pm = 3'd0; nrd = 0; tag = "R9";
        a1 = pt + (64'(va[42:33]) << 3);
        a2 = (64'(e1[63:32]) << 13) + (64'(va[32:23]) << 3);
        a3 = (64'(e2[63:32]) << 13) + (64'(va[22:13]) << 3);
        if (va[63:43] != 21'h0 && va[63:43] != 21'h1FFFFF) begin
            f = 3'd2; tag = "R1";
        end else if (va[63] && va[42:41] == 2'b10) begin
            if (pv) begin f = 3'd2; tag = "R3"; end
            else begin
                tag = "R2"; pm = 3'b111;
                pa = {20'd0, va[40], 3'd0, va[39:0]};
            end
        end else begin
            nrd = 1;
            if (!e1[0]) begin f = 3'd1; tag = "R5"; end
            else if (!e1[8]) begin f = 3'd2; tag = "R5"; end
            else begin
                nrd = 2;
                if (!e2[0]) begin f = 3'd1; tag = "R5"; end
                else if (!e2[8]) begin f = 3'd2; tag = "R5"; end
                else begin
                    nrd = 3;
                    g = {e3[8+pv], e3[12+pv], e3[8+pv]};
                    r = g & ~e3[3:1];
                    if (!e3[0]) begin f = 3'd1; tag = "R6"; end
                    else if (acc != 0 && (g & acc) == 0) begin f = 3'd2; tag = "R7"; end
                    else if (acc != 0 && (r & acc) == 0) begin
                        tag = "R8";
                        f = acc[2] ? 3'd5 : acc[1] ? 3'd4 : 3'd3;
                    end else begin
                        pm = r;
                        pa = (64'(e3[63:32]) << 13) | 64'(va[12:0]);
                    end
                end
            end
        end
    endtask

    task automatic run(input logic [63:0] va, input logic pv, input logic [2:0] acc,
                       input logic [63:0] pt, input logic [63:0] e1,
                       input logic [63:0] e2, input logic [63:0] e3);
        logic [2:0] ef; logic [63:0] epa; logic [2:0] epm; int enrd;
        logic [63:0] a1; logic [63:0] a2; logic [63:0] a3; string tag;
        logic [63:0] ea [0:2];
        int cyc = 0;
        model(va, pv, acc, pt, e1, e2, e3, ef, epa, epm, enrd, a1, a2, a3, tag);
        ea[0] = a1; ea[1] = a2; ea[2] = a3;
        tbl[0] = e1; tbl[1] = e2; tbl[2] = e3; tbl[3] = '0;
        rd_cnt = 0;
        @(negedge clk);
        check("R11", "ready before start", 64'(ready_o), 64'd1);
        va_i = va; priv_i = pv; acc_i = acc; ptbr_i = pt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        check(tag, "fault", 64'(fault_o), 64'(ef));
        check(tag, "pa", pa_o, epa);
        check(tag, "perm", 64'(perm_o), 64'(epm));
        check("R10", "read count", 64'(rd_cnt), 64'(enrd));
        if (enrd == 0) check(tag, "early latency", 64'(cyc), 64'd0);
        for (int i = 0; i < enrd && i < 3; i++) check("R4", "table address", seen[i], ea[i]);
        @(negedge clk);
        check("R11", "done pulse ends", 64'(done_o), 64'd0);
    endtask

    function automatic logic [63:0] ent(input logic [31:0] frame, input logic [31:0] lo);
        return {frame, lo};
    endfunction

    // Global watchdog.
    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] va;
        logic [63:0] e1;
        logic [63:0] e2;
        logic [63:0] e3;
        logic [63:0] kpt;
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset ready", 64'(ready_o), 64'd1);
        check("R11", "reset done", 64'(done_o), 64'd0);
        check("R10", "reset mem_req", 64'(mem_req_o), 64'd0);

        kpt = 64'h0000_0000_0040_0000;
        e1  = ent(32'h0000_0123, 32'h0000_0101);
        e2  = ent(32'h0000_0456, 32'h0000_0101);
        // R1: malformed sign extension
        run(64'h8000_1000_0000_0000, 1'b0, 3'b001, kpt, e1, e2, '0);
        // R2: direct window with bit 40 relocated
        run(64'hFFFF_FD12_3456_7890, 1'b0, 3'b010, kpt, e1, e2, '0);
        // R3: direct window at user privilege
        run(64'hFFFF_FC00_0000_1000, 1'b1, 3'b001, kpt, e1, e2, '0);
        // R5: first level not valid; second level lacks kernel read
        run(64'h0000_0123_4567_8000, 1'b0, 3'b001, kpt, ent(32'h77, 32'h100), e2, '0);
        run(64'h0000_0123_4567_8000, 1'b0, 3'b001, kpt, e1, ent(32'h88, 32'h001), '0);
        // R6: leaf not valid
        run(64'h0000_0456_789A_BCDE, 1'b0, 3'b001, kpt, e1, e2, ent(32'h99, 32'h1100));
        // R7: user read with only kernel enables
        run(64'h0000_0222_3333_4444, 1'b1, 3'b001, kpt, e1, e2, ent(32'hAB, 32'h1101));
        // R9: user write granted by user write enable
        run(64'h0000_0555_6666_7777, 1'b1, 3'b010, kpt, e1, e2, ent(32'hCDE, 32'h2201));
        // R8: execute+read with FOR and FOE -> FOE
        run(64'h0000_0111_2222_3333, 1'b0, 3'b101, kpt, e1, e2, ent(32'h5, 32'h110B));
        // R8: read+write with FOR and FOW -> FOW
        run(64'h0000_0111_2222_3333, 1'b0, 3'b011, kpt, e1, e2, ent(32'h5, 32'h1107));
        // R8: read with FOR -> FOR
        run(64'h0000_0111_2222_3333, 1'b0, 3'b001, kpt, e1, e2, ent(32'h5, 32'h1103));
        // R9: empty request succeeds
        run(64'h0000_0111_2222_3333, 1'b1, 3'b000, kpt, e1, e2, ent(32'h6, 32'h0001));

        for (int k = 0; k < 300; k++) begin
            logic [63:0] rv;
            rv = {$urandom, $urandom};
            case ($urandom % 4)
                0: va = {1'b1, 8'h00, rv[54:0]};
                1: va = {21'h1FFFFF, 2'b10, rv[40:0]};
                2: va = {21'h0, rv[42:0]};
                default: va = {21'h1FFFFF, 2'b0, rv[40:0]};
            endcase
            e1 = {$urandom, 16'h0, 7'h0, ($urandom % 8 != 0), 7'h0, ($urandom % 10 != 0)};
            e2 = {$urandom, 16'h0, 7'h0, ($urandom % 8 != 0), 7'h0, ($urandom % 10 != 0)};
            e3 = {$urandom, 16'h0, 2'b0, 2'($urandom), 2'b0, 2'($urandom), 4'h0,
                  3'($urandom % 3 == 0 ? $urandom : 0), ($urandom % 10 != 0)};
            run(va, 1'($urandom), 3'($urandom), {$urandom, 19'($urandom), 13'h0}, e1, e2, e3);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule